// File: doc/BRIEF.md
# Rectangle Fill and Block Copy Engine

This block is a small 2D drawing engine. A host pushes 32-bit words into a command queue. The engine decodes packed multi-word commands and draws into an internal framebuffer of 16-bit pixels. It runs two operations: a solid rectangle fill with the foreground colour, and a screen-to-screen copy of a rectangle. For a copy, the command word carries a 2-bit traversal code that sets the direction on each axis. With the right code, a source and destination that overlap are copied without corruption.

The host writes configuration registers through the same write port: foreground colour, pixel pitch per row, and an inclusive clip window. A soft-reset strobe is also on this port. The host can read two words: the number of free queue slots, and a busy status. A debug read port returns any framebuffer pixel. Once a command's parameters are complete, the engine draws one pixel per clock.

Top module: `rect_blit_engine`

## Requirements
- R1: The word 0x09410000 starts a fill. It is followed by a destination word (y in bits 31:16, x in bits 15:0) and a size word (height in bits 31:16, width in bits 15:0). The fill writes the foreground colour (write address 1) into every pixel of the rectangle.
- R2: A word with bits 31:24 = 0x0d, bits 23:18 = 6'b010001 and bits 15:0 = 0 starts a copy. It is followed by a source position word, a destination position word and a size word. Each position word has y in bits 31:16 and x in bits 15:0. The size word has height in bits 31:16 and width in bits 15:0. Each destination pixel receives the source pixel at the same offset. A source pixel outside the frame reads as 0.
- R3: The traversal code sits in bits 17:16 of the copy word. When bit 16 is set, x runs right to left; when bit 17 is set, y runs bottom to top. The host picks the code as follows: 0x44 when src_x ≥ dst_x and src_y ≥ dst_y; otherwise 0x46 when src_x ≥ dst_x; otherwise 0x45 when src_y ≥ dst_y; otherwise 0x47. With that choice, a copy between overlapping regions produces the same result as copying from a snapshot of the source.
- R4: A pixel is written only when xmin ≤ x ≤ xmax and ymin ≤ y ≤ ymax. The clip bounds are at write addresses 3 to 6 (xmin, xmax, ymin, ymax). After reset they hold 0, frame width, 0 and frame height.
- R5: Pixel (x,y) maps to framebuffer address y·pitch + x. The pitch is at write address 2 and resets to the frame width. A pixel with x ≥ pitch, or with an address beyond the framebuffer, is not written.
- R6: A read with rdSel=0 returns the number of free queue slots (8 − occupancy). A queue write (address 0) while no slot is free is discarded.
- R7: A read with rdSel=1 returns the status word, with busy flags under mask 0x131: bit 0 drawing, bit 4 queue not empty, bit 5 command waiting for parameters, bit 8 copy drawing. The status word is 0 when the engine is idle and the queue is empty.
- R8: Writing 1 to bit 0 at address 7 empties the queue and returns the engine to idle on the next cycle. The colour, pitch and clip registers keep their values.
- R9: When the engine is idle, a word that is neither a fill nor a valid copy word is consumed alone and has no effect on the framebuffer.
- R10: A command with width w and height h draws for exactly w·h cycles (status bit 0 high), one pixel per cycle.
- R11: A command with zero width or zero height writes no pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears queue, registers and framebuffer |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 3 | 0 queue, 1 colour, 2 pitch, 3 xmin, 4 xmax, 5 ymin, 6 ymax, 7 soft reset |
| wrData | input | 32 | Write data |
| rdSel | input | 1 | 0 selects free-slot count, 1 selects status |
| rdData | output | 32 | Read data (combinational) |
| pixAddr | input | AW | Framebuffer read address |
| pixData | output | 16 | Framebuffer pixel at pixAddr |

## Verification
The bench paints each pixel with a value unique to its position, so any misplaced or misordered pixel shows up. It then copies a 6×4 block to every destination within two pixels of the source, on both axes. This covers all four traversal codes and every overlap geometry, including rows and columns that coincide. Fills are run:
- against a narrowed clip window, which separates inclusive bounds from exclusive ones;
- at a reduced pitch, which separates address arithmetic from x/y bounds checks;
- off the frame edge;
- with zero size.

Queue tests fill the queue behind a long command, then check stray words, soft reset in the middle of a command, and the exact draw duration.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam logic [31:0] FILL_WORD = 32'h0941_0000;
  localparam logic [7:0]  COPY_TOP  = 8'h0d;
  localparam logic [5:0]  COPY_MID  = 6'b010001;

  typedef enum logic [1:0] {ST_IDLE, ST_PARAM, ST_RUN} engState_t;

  typedef struct packed {
    logic       pop;
    logic       ldCmd;
    logic       cmdCopy;
    logic [1:0] cmdDir;
    logic       ldParam;
    logic [1:0] paramIdx;
    logic       step;
  } ctrlStrobes_t;
endpackage

// File: rtl/blit_fifo.sv
module blit_fifo #(
  parameter int DEPTH = 8,
  parameter int W = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] popData,
  output logic         empty,
  output logic [CW-1:0] freeCnt
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] used;
  logic doPush, doPop;

  assign empty   = (used == '0);
  assign doPush  = push && (used != CW'(DEPTH));
  assign doPop   = pop && !empty;
  assign popData = mem[rdPtr];
  assign freeCnt = CW'(DEPTH) - used;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      used  <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= pushData;
        wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (doPop) rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: used <= used;
      endcase
    end
  end
endmodule

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         fifoEmpty,
  input  logic [31:0]  word,
  input  logic         lastPix,
  output ctrlStrobes_t strb,
  output logic         running,
  output logic         collecting,
  output logic         copyRun
);
  engState_t state;
  logic [1:0] idx;
  logic isCopy;
  logic copyWord, zeroSize;

  assign copyWord = (word[31:24] == COPY_TOP) && (word[23:18] == COPY_MID) &&
                    (word[15:0] == 16'h0);
  assign zeroSize = (word[15:0] == 16'h0) || (word[31:16] == 16'h0);

  always_comb begin
    strb = '0;
    case (state)
      ST_IDLE: if (!fifoEmpty) begin
        strb.pop = 1'b1;
        if (word == FILL_WORD) begin
          strb.ldCmd = 1'b1;
        end else if (copyWord) begin
          strb.ldCmd   = 1'b1;
          strb.cmdCopy = 1'b1;
          strb.cmdDir  = word[17:16];
        end
      end
      ST_PARAM: if (!fifoEmpty) begin
        strb.pop      = 1'b1;
        strb.ldParam  = 1'b1;
        strb.paramIdx = idx;
      end
      ST_RUN: strb.step = 1'b1;
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      state  <= ST_IDLE;
      idx    <= 2'd0;
      isCopy <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (strb.ldCmd) begin
          state  <= ST_PARAM;
          idx    <= strb.cmdCopy ? 2'd0 : 2'd1;
          isCopy <= strb.cmdCopy;
        end
        ST_PARAM: if (strb.ldParam) begin
          if (idx == 2'd2) state <= zeroSize ? ST_IDLE : ST_RUN;
          else idx <= idx + 2'd1;
        end
        ST_RUN: if (lastPix) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign running    = (state == ST_RUN);
  assign collecting = (state == ST_PARAM);
  assign copyRun    = running && isCopy;
endmodule

// File: rtl/blit_datapath.sv
module blit_datapath
  import blit_pkg::*;
#(
  parameter int FB_W = 16,
  parameter int FB_H = 8,
  localparam int DEPTH = FB_W * FB_H,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  ctrlStrobes_t strb,
  input  logic [31:0]  word,
  input  logic         regWe,
  input  logic [2:0]   regAddr,
  input  logic [15:0]  regData,
  input  logic [AW-1:0] pixAddr,
  output logic [15:0]  pixData,
  output logic         lastPix,
  output logic         pixWe
);
  logic [15:0] fgColor, pitch, clipXmin, clipXmax, clipYmin, clipYmax;
  logic [31:0] srcPos, dstPos, sizeWord;
  logic        isCopy;
  logic [1:0]  dir;
  logic [15:0] cx, cy, rw, rh, xOff, yOff;
  logic [16:0] dX, dY, sX, sY;
  logic [33:0] dAddr, sAddr;
  logic        dOk, sOk, clipOk;
  logic [15:0] srcPix;
  logic [15:0] fb [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      fgColor  <= '0;
      pitch    <= 16'(FB_W);
      clipXmin <= '0;
      clipXmax <= 16'(FB_W);
      clipYmin <= '0;
      clipYmax <= 16'(FB_H);
    end else if (regWe) begin
      case (regAddr)
        3'd1: fgColor  <= regData;
        3'd2: pitch    <= regData;
        3'd3: clipXmin <= regData;
        3'd4: clipXmax <= regData;
        3'd5: clipYmin <= regData;
        3'd6: clipYmax <= regData;
        default: ;
      endcase
    end
  end

  assign rw = sizeWord[15:0];
  assign rh = sizeWord[31:16];

  always_ff @(posedge clk) begin
    if (rst) begin
      isCopy <= 1'b0;
      dir    <= 2'b00;
      srcPos <= '0;
      dstPos <= '0;
      sizeWord <= '0;
      cx <= '0;
      cy <= '0;
    end else begin
      if (strb.ldCmd) begin
        isCopy <= strb.cmdCopy;
        dir    <= strb.cmdDir;
      end
      if (strb.ldParam) begin
        case (strb.paramIdx)
          2'd0: srcPos <= word;
          2'd1: dstPos <= word;
          default: begin
            sizeWord <= word;
            cx <= '0;
            cy <= '0;
          end
        endcase
      end else if (strb.step) begin
        if (cx == rw - 16'd1) begin
          cx <= '0;
          cy <= cy + 16'd1;
        end else begin
          cx <= cx + 16'd1;
        end
      end
    end
  end

  assign lastPix = (cx == rw - 16'd1) && (cy == rh - 16'd1);
  assign xOff = dir[0] ? (rw - 16'd1 - cx) : cx;
  assign yOff = dir[1] ? (rh - 16'd1 - cy) : cy;

  assign dX = {1'b0, dstPos[15:0]}  + {1'b0, xOff};
  assign dY = {1'b0, dstPos[31:16]} + {1'b0, yOff};
  assign sX = {1'b0, srcPos[15:0]}  + {1'b0, xOff};
  assign sY = {1'b0, srcPos[31:16]} + {1'b0, yOff};

  assign dAddr = 34'(dY) * 34'(pitch) + 34'(dX);
  assign sAddr = 34'(sY) * 34'(pitch) + 34'(sX);
  assign dOk = (dX < {1'b0, pitch}) && (dAddr < 34'(DEPTH));
  assign sOk = (sX < {1'b0, pitch}) && (sAddr < 34'(DEPTH));
  assign clipOk = (dX >= {1'b0, clipXmin}) && (dX <= {1'b0, clipXmax}) &&
                  (dY >= {1'b0, clipYmin}) && (dY <= {1'b0, clipYmax});

  assign srcPix  = sOk ? fb[sAddr[AW-1:0]] : 16'h0;
  assign pixWe   = strb.step && dOk && clipOk;
  assign pixData = fb[pixAddr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) fb[i] <= '0;
    end else if (pixWe) begin
      fb[dAddr[AW-1:0]] <= isCopy ? srcPix : fgColor;
    end
  end
endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
  import blit_pkg::*;
#(
  parameter int FB_W = 16,
  parameter int FB_H = 8,
  parameter int FIFO_DEPTH = 8,
  localparam int AW = $clog2(FB_W * FB_H),
  localparam int FCW = $clog2(FIFO_DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrEn,
  input  logic [2:0]    wrAddr,
  input  logic [31:0]   wrData,
  input  logic          rdSel,
  output logic [31:0]   rdData,
  input  logic [AW-1:0] pixAddr,
  output logic [15:0]   pixData
);
  ctrlStrobes_t strb;
  logic flush, fifoPush, fifoEmpty, fifoPop, regWe;
  logic [31:0] fifoWord, statusWord;
  logic [FCW-1:0] freeCnt;
  logic lastPix, pixWe, running, collecting, copyRun;

  assign flush    = wrEn && (wrAddr == 3'd7) && wrData[0];
  assign fifoPush = wrEn && (wrAddr == 3'd0);
  assign regWe    = wrEn && (wrAddr != 3'd0) && (wrAddr != 3'd7);
  assign fifoPop  = strb.pop;

  blit_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) fifo_i (
    .clk(clk), .rst(rst), .flush(flush), .push(fifoPush), .pushData(wrData),
    .pop(fifoPop), .popData(fifoWord), .empty(fifoEmpty), .freeCnt(freeCnt)
  );

  blit_ctrl ctrl_i (
    .clk(clk), .rst(rst), .flush(flush), .fifoEmpty(fifoEmpty), .word(fifoWord),
    .lastPix(lastPix), .strb(strb), .running(running), .collecting(collecting),
    .copyRun(copyRun)
  );

  blit_datapath #(.FB_W(FB_W), .FB_H(FB_H)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .word(fifoWord), .regWe(regWe),
    .regAddr(wrAddr), .regData(wrData[15:0]), .pixAddr(pixAddr),
    .pixData(pixData), .lastPix(lastPix), .pixWe(pixWe)
  );

  assign statusWord = 32'({copyRun, 2'b00, collecting, !fifoEmpty, 3'b000, running});
  assign rdData = rdSel ? statusWord : 32'(freeCnt);
endmodule

// File: rtl/rect_blit_engine_chk.sv
module rect_blit_engine_chk #(
  parameter int DEPTH = 8,
  localparam int FCW = $clog2(DEPTH) + 1
) (
  input logic           clk,
  input logic           rst,
  input logic           wrEn,
  input logic [2:0]     wrAddr,
  input logic [31:0]    wrData,
  input logic [FCW-1:0] freeCnt,
  input logic [31:0]    statusWord,
  input logic           fifoPop,
  input logic           pixWe,
  input logic           running
);
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (rst)
    freeCnt <= FCW'(DEPTH)); // R6
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == 3'd0 && freeCnt == '0 && !fifoPop) |=> freeCnt == '0); // R6
  AST_WORDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (freeCnt != FCW'(DEPTH)) |-> statusWord[4]); // R7
  AST_SRST_IDLE: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == 3'd7 && wrData[0]) |=> (statusWord == 32'h0 && freeCnt == FCW'(DEPTH))); // R8
  AST_POP_ONE: assert property (@(posedge clk) disable iff (rst)
    (fifoPop && !wrEn) |=> freeCnt == FCW'($past(freeCnt) + 1'b1)); // R9
  AST_DRAW_RUN: assert property (@(posedge clk) disable iff (rst)
    pixWe |-> running); // R10
endmodule

bind rect_blit_engine rect_blit_engine_chk #(.DEPTH(FIFO_DEPTH)) chk_i (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .freeCnt(freeCnt), .statusWord(statusWord), .fifoPop(fifoPop),
  .pixWe(pixWe), .running(running)
);

// File: tb/rect_blit_engine_tb_top.sv
module rect_blit_engine_tb_top;
  localparam int FB_W = 16;
  localparam int FB_H = 8;
  localparam int DEPTH = FB_W * FB_H;
  localparam logic [31:0] FILLW = 32'h0941_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic rdSel = 1'b0;
  logic [31:0] rdData;
  logic [6:0] pixAddr = '0;
  logic [15:0] pixData;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [15:0] exp [DEPTH];
  logic [15:0] snap [DEPTH];
  int mPitch = FB_W, cXmin = 0, cXmax = FB_W, cYmin = 0, cYmax = FB_H;

  always #10 clk = ~clk;

  rect_blit_engine dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .pixAddr(pixAddr), .pixData(pixData)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitIdle();
    rdSel = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (rdData == 32'h0) break;
    end
    rdSel = 1'b0;
  endtask

  function automatic void mPut(input int x, input int y, input logic [15:0] v);
    if (x >= 0 && y >= 0 && x < mPitch && y * mPitch + x < DEPTH &&
        x >= cXmin && x <= cXmax && y >= cYmin && y <= cYmax)
      exp[y * mPitch + x] = v;
  endfunction

  function automatic void mFill(input int x, input int y, input int w, input int h,
                                input logic [15:0] c);
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++) mPut(x + i, y + j, c);
  endfunction

  task automatic fill(input int x, input int y, input int w, input int h,
                      input logic [15:0] c);
    wr(3'd1, 32'(c));
    wr(3'd0, FILLW);
    wr(3'd0, 32'((y << 16) | x));
    wr(3'd0, 32'((h << 16) | w));
    mFill(x, y, w, h, c);
    waitIdle();
  endtask

  task automatic blit(input int sx, input int sy, input int dx, input int dy,
                      input int w, input int h);
    logic [7:0] code;
    if (sx >= dx && sy >= dy) code = 8'h44;
    else if (sx >= dx && sy <= dy) code = 8'h46;
    else if (sx <= dx && sy >= dy) code = 8'h45;
    else code = 8'h47;
    wr(3'd0, 32'h0d00_0000 | (32'(code) << 16));
    wr(3'd0, 32'((sy << 16) | sx));
    wr(3'd0, 32'((dy << 16) | dx));
    wr(3'd0, 32'((h << 16) | w));
    for (int k = 0; k < DEPTH; k++) snap[k] = exp[k];
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++) begin
        int x, y;
        logic [15:0] v;
        x = sx + i; y = sy + j;
        v = (x < mPitch && y * mPitch + x < DEPTH) ? snap[y * mPitch + x] : 16'h0;
        mPut(dx + i, dy + j, v);
      end
    waitIdle();
  endtask

  task automatic fbCheck(input string tag);
    int bad = -1;
    logic [15:0] got = '0;
    for (int a = 0; a < DEPTH; a++) begin
      pixAddr = 7'(a);
      #1;
      if (bad < 0 && pixData !== exp[a]) begin
        bad = a; got = pixData;
      end
    end
    checks++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s pixel %0d actual=0x%0h expected=0x%0h", tag, bad, got, exp[bad]);
    end
  endtask

  task automatic paint();
    for (int y = 0; y < FB_H; y++)
      for (int x = 0; x < FB_W; x++)
        fill(x, y, 1, 1, 16'h1000 | 16'(y << 8) | 16'(x));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int cnt;
    for (int k = 0; k < DEPTH; k++) exp[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6 R7 reset state
    rdSel = 1'b0; #1; check("R6 reset free slots", rdData, 32'd8);
    rdSel = 1'b1; #1; check("R7 reset status", rdData, 32'h0);
    rdSel = 1'b0;
    fbCheck("R1 reset framebuffer clear");

    // R7 collecting flag, R8 soft reset mid-command
    wr(3'd1, 32'h0555);
    wr(3'd0, FILLW);
    @(negedge clk);
    rdSel = 1'b1; #1; check("R7 waiting for parameters", rdData, 32'h20);
    wr(3'd0, 32'((2 << 16) | 2));
    wr(3'd7, 32'h1);
    #1; check("R8 status after soft reset", rdData, 32'h0);
    rdSel = 1'b0; #1; check("R8 free after soft reset", rdData, 32'd8);
    wr(3'd0, FILLW);
    wr(3'd0, 32'((3 << 16) | 3));
    wr(3'd0, 32'((1 << 16) | 2));
    mFill(3, 3, 2, 1, 16'h0555);
    waitIdle();
    fbCheck("R8 fill after soft reset keeps colour");

    // R1 plain fills
    fill(1, 1, 4, 2, 16'h00AA);
    fill(0, 7, 16, 1, 16'h00BB);
    fbCheck("R1 fill rectangles");

    // R4 clip window inclusive
    wr(3'd3, 3); wr(3'd4, 9); wr(3'd5, 2); wr(3'd6, 5);
    cXmin = 3; cXmax = 9; cYmin = 2; cYmax = 5;
    fill(0, 0, 16, 8, 16'h1234);
    fbCheck("R4 clipped fill");
    wr(3'd3, 0); wr(3'd4, FB_W); wr(3'd5, 0); wr(3'd6, FB_H);
    cXmin = 0; cXmax = FB_W; cYmin = 0; cYmax = FB_H;

    // R5 pitch and frame edges
    wr(3'd2, 8); mPitch = 8;
    fill(2, 1, 10, 3, 16'h0BEE);
    fbCheck("R5 fill at pitch 8");
    wr(3'd2, FB_W); mPitch = FB_W;
    fill(12, 6, 8, 5, 16'h0CCC);
    fbCheck("R5 fill over frame edge");

    // R11 zero size
    fill(4, 4, 0, 3, 16'h0DDD);
    fill(4, 4, 3, 0, 16'h0DDD);
    fbCheck("R11 zero-size fills");

    // R9 stray and unknown words
    wr(3'd1, 32'h0777);
    wr(3'd0, 32'h0003_0002);
    wr(3'd0, 32'h1234_5678);
    wr(3'd0, 32'h0d48_0000);
    wr(3'd0, FILLW);
    wr(3'd0, 32'((2 << 16) | 2));
    wr(3'd0, 32'((1 << 16) | 1));
    mFill(2, 2, 1, 1, 16'h0777);
    waitIdle();
    fbCheck("R9 stray words dropped");

    // R6 full queue drops writes
    fill(0, 0, 16, 8, 16'h0);
    wr(3'd1, 32'h0AAA);
    wr(3'd0, FILLW); wr(3'd0, 32'h0); wr(3'd0, 32'((4 << 16) | 16));
    wr(3'd0, FILLW); wr(3'd0, 32'((5 << 16) | 1)); wr(3'd0, 32'((1 << 16) | 2));
    wr(3'd0, FILLW); wr(3'd0, 32'((6 << 16) | 3)); wr(3'd0, 32'((2 << 16) | 2));
    wr(3'd0, FILLW); wr(3'd0, 32'((7 << 16) | 9));
    rdSel = 1'b0; #1; check("R6 queue full", rdData, 32'd0);
    wr(3'd0, 32'h0008_0010);
    #1; check("R6 still full after dropped write", rdData, 32'd0);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (rdData != 32'd0) break;
    end
    wr(3'd0, 32'((1 << 16) | 4));
    mFill(0, 0, 16, 4, 16'h0AAA); mFill(1, 5, 2, 1, 16'h0AAA);
    mFill(3, 6, 2, 2, 16'h0AAA); mFill(9, 7, 4, 1, 16'h0AAA);
    waitIdle();
    fbCheck("R6 queued fills without dropped word");

    // R10 pixel-per-clock duration
    wr(3'd1, 32'h0321);
    wr(3'd0, FILLW); wr(3'd0, 32'((1 << 16) | 1)); wr(3'd0, 32'((3 << 16) | 5));
    mFill(1, 1, 5, 3, 16'h0321);
    rdSel = 1'b1; cnt = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (rdData[0]) cnt++;
      if (rdData == 32'h0) break;
    end
    rdSel = 1'b0;
    check("R10 draw cycles for 5x3", 32'(cnt), 32'd15);

    // R2 disjoint copy, R3 overlapping sweep
    paint();
    blit(0, 0, 9, 4, 5, 3);
    fbCheck("R2 disjoint copy");
    for (int dy = -2; dy <= 2; dy++)
      for (int dx = -2; dx <= 2; dx++) begin
        paint();
        blit(5, 2, 5 + dx, 2 + dy, 6, 4);
        fbCheck($sformatf("R3 overlap copy shift %0d,%0d", dx, dy));
      end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule